// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and can pass data between them in either direction. Each side can be driven with live data taken from the other bus or with a stored copy. The data width is a parameter and defaults to eight bits. Each bus appears at the ports as an input vector, an output vector and an output-enable, so the block needs no tri-state pins. A bus that is not driven presents zeros on its output vector.

There are two storage registers. One keeps a snapshot of bus A and the other keeps a snapshot of bus B. Each register is loaded by its own capture strobe. The strobes are sampled by the single system clock, and a register loads when its strobe shows a rising edge. Capture does not depend on the enable and direction controls, so a bus can be recorded while both outputs are off and replayed later.

The output controls are combinational:
- An active-low enable turns driving on or off.
- A direction input chooses the bus to drive: B when HIGH, A when LOW.
- For each direction, a source select chooses live data (LOW) or stored data (HIGH).

Top module: `dualbus_xcvr`

## Requirements
- R1: A synchronous active-high reset `rst` clears both storage registers to zero. After reset, selecting stored data on an enabled bus gives zero.
- R2: When `cap_a_stb` is sampled HIGH on a clock edge and was sampled LOW on the edge before, the A register loads the value of `a_in` at that edge.
- R3: When `cap_b_stb` is sampled HIGH on a clock edge and was sampled LOW on the edge before, the B register loads the value of `b_in` at that edge.
- R4: While B is driven, `b_out` equals `a_in` when `sel_ab` is 0 (live) and equals the A register when `sel_ab` is 1 (stored).
- R5: While A is driven, `a_out` equals `b_in` when `sel_ba` is 0 (live) and equals the B register when `sel_ba` is 1 (stored).
- R6: With `en_n` = 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0. The two output-enables are never both 1.
- R7: With `en_n` = 1, both output-enables are 0. Any bus whose output-enable is 0 shows all zeros on its output vector.
- R8: Captures take place whatever the values of `en_n`, `dir`, `sel_ab` and `sel_ba`. Loading one register leaves the other unchanged.
- R9: A strobe that is held HIGH for several clock cycles captures only once, at its first HIGH sample. Later changes on the bus while the strobe stays HIGH are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive bus B, 0: drive bus A |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 A register |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 B register |
| cap_a_stb | input | 1 | Capture strobe for the A register (rising edge) |
| cap_b_stb | input | 1 | Capture strobe for the B register (rising edge) |
| a_in | input | W | Value present on bus A |
| b_in | input | W | Value present on bus B |
| a_out | output | W | Value to drive onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | W | Value to drive onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench runs all sixteen combinations of enable, direction and the two selects. In each one it keeps the live values and the stored values different, so a design that swaps the lanes or inverts a select returns the wrong data, and a design that drives both buses or leaks data onto a disabled bus fails the enable checks.

It loads both registers while the outputs are off and with the other controls set against the capture. A design that gates capture with the enable, or that writes both registers from one strobe, then shows a stale or corrupted stored value.

It holds a strobe HIGH while the bus changes underneath it. A level-sensitive design would store the later value instead of the value at the edge.

// File: rtl/dualbus_pkg.sv
package dualbus_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic drv_a;
        logic drv_b;
    } drive_t;

    localparam int NUM_LANES = 2;

    // Lane 0 carries data from A toward B, lane 1 from B toward A.
    localparam int LANE_AB = 0;
    localparam int LANE_BA = 1;

    function automatic drive_t decode_drive(input logic en_n, input logic dir);
        drive_t d;
        d.drv_a = ~en_n & ~dir;
        d.drv_b = ~en_n &  dir;
        return d;
    endfunction

endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
    input  logic clk,
    input  logic stb,
    output logic rise
);
    logic stb_d;

    // Free-running delay so the edge test matches the sampled strobe history.
    always_ff @(posedge clk) begin
        stb_d <= stb;
    end

    assign rise = stb & ~stb_d;
endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/route_mux.sv
module route_mux
    import dualbus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    input  src_sel_e     sel,
    input  logic         drive,
    output logic [W-1:0] out
);
    always_comb begin
        if (!drive) begin
            out = '0;
        end else if (sel == SRC_STORED) begin
            out = stored;
        end else begin
            out = live;
        end
    end
endmodule

// File: rtl/dualbus_xcvr.sv
module dualbus_xcvr
    import dualbus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         cap_a_stb,
    input  logic         cap_b_stb,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    drive_t drive;

    logic [NUM_LANES-1:0][W-1:0] src_bus;
    logic [NUM_LANES-1:0][W-1:0] stored_q;
    logic [NUM_LANES-1:0][W-1:0] lane_out;
    logic [NUM_LANES-1:0]        lane_stb;
    logic [NUM_LANES-1:0]        lane_load;
    logic [NUM_LANES-1:0]        lane_drv;
    src_sel_e                    lane_sel [NUM_LANES];

    assign drive = decode_drive(en_n, dir);

    assign src_bus[LANE_AB]  = a_in;
    assign src_bus[LANE_BA]  = b_in;
    assign lane_stb[LANE_AB] = cap_a_stb;
    assign lane_stb[LANE_BA] = cap_b_stb;
    assign lane_sel[LANE_AB] = src_sel_e'(sel_ab);
    assign lane_sel[LANE_BA] = src_sel_e'(sel_ba);
    assign lane_drv[LANE_AB] = drive.drv_b;
    assign lane_drv[LANE_BA] = drive.drv_a;

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        strobe_rise u_rise (
            .clk  (clk),
            .stb  (lane_stb[ln]),
            .rise (lane_load[ln])
        );

        capture_reg #(.W(W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .load (lane_load[ln]),
            .d    (src_bus[ln]),
            .q    (stored_q[ln])
        );

        route_mux #(.W(W)) u_mux (
            .live   (src_bus[ln]),
            .stored (stored_q[ln]),
            .sel    (lane_sel[ln]),
            .drive  (lane_drv[ln]),
            .out    (lane_out[ln])
        );
    end

    assign b_out = lane_out[LANE_AB];
    assign a_out = lane_out[LANE_BA];
    assign b_oe  = drive.drv_b;
    assign a_oe  = drive.drv_a;
endmodule

// File: rtl/dualbus_xcvr_chk.sv
module dualbus_xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         cap_a_stb,
    input logic         cap_b_stb,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] a_reg,
    input logic [W-1:0] b_reg
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (a_reg == '0 && b_reg == '0));

    a_r2_capture_a: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_a_stb) |=> (a_reg == $past(a_in)));

    a_r3_capture_b: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_b_stb) |=> (b_reg == $past(b_in)));

    a_r4_live_ab: assert property (@(posedge clk) disable iff (rst)
        (b_oe && !sel_ab) |-> (b_out == a_in));

    a_r5_live_ba: assert property (@(posedge clk) disable iff (rst)
        (a_oe && !sel_ba) |-> (a_out == b_in));

    a_r6_single_bus: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));

    a_r6_dir_b: assert property (@(posedge clk) disable iff (rst)
        (!en_n && dir) |-> (b_oe && !a_oe));

    a_r7_disabled: assert property (@(posedge clk) disable iff (rst)
        en_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    a_r8_hold_a: assert property (@(posedge clk) disable iff (rst)
        !$rose(cap_a_stb) |=> $stable(a_reg));

    a_r8_hold_b: assert property (@(posedge clk) disable iff (rst)
        !$rose(cap_b_stb) |=> $stable(b_reg));
endmodule

bind dualbus_xcvr dualbus_xcvr_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_n      (en_n),
    .dir       (dir),
    .sel_ab    (sel_ab),
    .sel_ba    (sel_ba),
    .cap_a_stb (cap_a_stb),
    .cap_b_stb (cap_b_stb),
    .a_in      (a_in),
    .b_in      (b_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .a_reg     (stored_q[0]),
    .b_reg     (stored_q[1])
);

// File: tb/sim_dualbus_xcvr.sv
`timescale 1ns/1ps
module sim_dualbus_xcvr;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_n = 1'b1;
    logic         dir = 1'b0;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic         cap_a_stb = 1'b0;
    logic         cap_b_stb = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_out;
    logic         b_oe;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [W-1:0] mdl_a = '0;
    logic [W-1:0] mdl_b = '0;

    always #4 clk = ~clk;

    dualbus_xcvr #(.W(W)) u0 (
        .clk(clk), .rst(rst), .en_n(en_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba),
        .cap_a_stb(cap_a_stb), .cap_b_stb(cap_b_stb),
        .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // Drive controls just after a falling edge; check after settling.
    task automatic set_ctl(input logic e, input logic d, input logic sab, input logic sba);
        @(negedge clk);
        en_n = e; dir = d; sel_ab = sab; sel_ba = sba;
        #1;
    endtask

    task automatic check_outputs(input string req);
        logic xa, xb;
        logic [W-1:0] ea, eb;
        xa = !en_n && !dir;
        xb = !en_n && dir;
        eb = xb ? (sel_ab ? mdl_a : a_in) : '0;
        ea = xa ? (sel_ba ? mdl_b : b_in) : '0;
        chk({req, " a_oe"}, {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, xa});
        chk({req, " b_oe"}, {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, xb});
        chk({req, " a_out"}, a_out, ea);
        chk({req, " b_out"}, b_out, eb);
    endtask

    task automatic pulse_a(input logic [W-1:0] v);
        @(negedge clk);
        a_in = v; cap_a_stb = 1'b1;
        @(negedge clk);
        cap_a_stb = 1'b0;
        mdl_a = v;
    endtask

    task automatic pulse_b(input logic [W-1:0] v);
        @(negedge clk);
        b_in = v; cap_b_stb = 1'b1;
        @(negedge clk);
        cap_b_stb = 1'b0;
        mdl_b = v;
    endtask

    task automatic t_reset();
        a_in = 8'h77; b_in = 8'h99;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R1 A reg zero after reset", b_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R1 B reg zero after reset", a_out, 8'h00);
    endtask

    task automatic t_capture_a();
        pulse_a(8'h5A);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        a_in = 8'h11; #1;
        chk("R2 stored A on b_out", b_out, 8'h5A);
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 live A on b_out", b_out, 8'h11);
    endtask

    task automatic t_capture_b();
        pulse_b(8'hC3);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        b_in = 8'h22; #1;
        chk("R3 stored B on a_out", a_out, 8'hC3);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 live B on a_out", a_out, 8'h22);
    endtask

    task automatic t_all_combos();
        a_in = 8'h3C; b_in = 8'hA5;
        for (int k = 0; k < 16; k++) begin
            set_ctl(k[3], k[2], k[1], k[0]);
            check_outputs($sformatf("R6 R7 R4 R5 combo %0d", k));
        end
    endtask

    task automatic t_capture_while_off();
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        pulse_a(8'hE1);
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
        pulse_b(8'h4D);
        check_outputs("R7 outputs off during capture");
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R8 A captured while off", b_out, 8'hE1);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R8 B captured while off", a_out, 8'h4D);
        // Loading only A must leave B intact.
        pulse_a(8'h0F);
        set_ctl(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R8 B untouched by A load", a_out, 8'h4D);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R8 A new value", b_out, 8'h0F);
    endtask

    task automatic t_strobe_held();
        @(negedge clk);
        a_in = 8'h81; cap_a_stb = 1'b1;
        @(negedge clk);
        a_in = 8'h18;
        @(negedge clk);
        a_in = 8'hFF;
        @(negedge clk);
        cap_a_stb = 1'b0;
        mdl_a = 8'h81;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R9 held strobe captures once", b_out, 8'h81);
        pulse_a(8'h66);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R2 recapture after release", b_out, 8'h66);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_capture_a();
        t_capture_b();
        t_all_combos();
        t_capture_while_off();
        t_strobe_held();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule